// File: doc/BRIEF.md
# Parallel Scan-Chain Self-Test Controller

This block runs a logic self-test over a design that has several scan chains, possibly of different lengths. A single pseudorandom pattern generator feeds the serial input of every chain on the same clock. Each chain takes a different generator stage, so neighbouring chains see streams that are offset from one another. On every shift clock, a multiple-input signature register folds in the serial output of each chain, one input bit per chain.

A session starts with a pulse on `start`. The controller then repeats a fixed cycle for a parameterised number of patterns. Each repeat is a shift phase as long as the longest chain, followed by a single capture cycle. Shorter chains simply pass extra bits through during the shift phase. A final shift phase unloads the last captured response. After it, `done` rises and the signature holds until the next start. The signature is then compared with a known good value elsewhere.

Top module: `stumps_bist`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `scan_en`, `capture_en` and `done` are 0 and `signature` is 0. The generator holds the seed `PRPG_SEED`.
- R2: A `start` seen while the block is idle or done does three things. It reloads the generator with `PRPG_SEED` and clears the signature to 0. From the next cycle the first shift phase begins (`scan_en` = 1).
- R3: The generator state p advances only on cycles with `scan_en` = 1, to `{p[PRPG_W-2:0], ^(p & PRPG_TAPS)}`. Chain i takes `scan_in[i] = p[i*(PRPG_W/NCHAIN)]` at all times.
- R4: On each cycle with `scan_en` = 1, the signature s becomes `{s[MISR_W-2:0], ^(s & MISR_TAPS)} ^ scan_out`. Here `scan_out` is zero-extended, so chain i lands on bit i. On all other cycles s holds.
- R5: Each shift phase lasts exactly `SHIFT_LEN` consecutive cycles, the longest chain length. Exactly one cycle with `capture_en` = 1 and `scan_en` = 0 follows it. The generator and signature hold during that cycle.
- R6: After `NPAT` captures, the block makes one more `SHIFT_LEN`-cycle unload phase. In the next cycle `done` rises.
- R7: While `done` = 1 and no `start` arrives, `done` stays 1, `signature` holds and both enables stay 0.
- R8: A `start` during the shift or capture phases has no effect on the sequence or the signature.
- R9: `scan_en` and `capture_en` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a self-test session |
| scan_out | input | NCHAIN | Serial output of each chain |
| scan_in | output | NCHAIN | Serial input to each chain |
| scan_en | output | 1 | Shift enable shared by all chains |
| capture_en | output | 1 | One-cycle functional capture |
| signature | output | MISR_W | Compacted response |
| done | output | 1 | Session complete, signature valid |

## Verification
The assertions cover three things. They count consecutive shift cycles before each capture and before `done` rises. They check that capture and shift are exclusive and that capture holds the signature. They check that a restart from done clears the signature. They take for granted that `rst_n` is applied before the first session. They also assume `scan_out` is driven to known values on every shift cycle.

The bench meets these assumptions with behavioural chains of lengths 8, 5, 7 and 3. The chains are held in reset until `rst_n` releases and always present a defined bit. The bench pulses `start` in idle, in done and in the middle of shifting. It also drops reset partway through a session.

// File: rtl/stumps_bist.sv
module stumps_bist #(
  parameter int NCHAIN    = 4,
  parameter int PRPG_W    = 16,
  parameter int MISR_W    = 16,
  parameter int SHIFT_LEN = 8,
  parameter int NPAT      = 4,
  parameter logic [PRPG_W-1:0] PRPG_SEED = 16'hACE1,
  parameter logic [PRPG_W-1:0] PRPG_TAPS = 16'hB400,
  parameter logic [MISR_W-1:0] MISR_TAPS = 16'hB400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [NCHAIN-1:0] scan_out,
  output logic [NCHAIN-1:0] scan_in,
  output logic              scan_en,
  output logic              capture_en,
  output logic [MISR_W-1:0] signature,
  output logic              done
);
  localparam int STRIDE = PRPG_W / NCHAIN;
  localparam int CW = $clog2(SHIFT_LEN + 1);
  localparam int PW = $clog2(NPAT + 1);

  typedef enum logic [2:0] {S_IDLE, S_SHIFT, S_CAPT, S_UNLD, S_FIN} st_t;

  st_t st;
  logic [PRPG_W-1:0] prpg;
  logic [MISR_W-1:0] misr;
  logic [CW-1:0] cnt;
  logic [PW-1:0] pat;

  wire [PRPG_W-1:0] prpg_nx = {prpg[PRPG_W-2:0], ^(prpg & PRPG_TAPS)};
  wire [MISR_W-1:0] misr_nx = {misr[MISR_W-2:0], ^(misr & MISR_TAPS)} ^ MISR_W'(scan_out);
  wire last_shift = (cnt == CW'(SHIFT_LEN - 1));

  for (genvar i = 0; i < NCHAIN; i++) begin : g_tap
    assign scan_in[i] = prpg[i*STRIDE];
  end

  assign scan_en    = (st == S_SHIFT) || (st == S_UNLD);
  assign capture_en = (st == S_CAPT);
  assign done       = (st == S_FIN);
  assign signature  = misr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      prpg <= PRPG_SEED;
      misr <= '0;
      cnt  <= '0;
      pat  <= '0;
    end else begin
      case (st)
        S_IDLE, S_FIN: if (start) begin
          st   <= S_SHIFT;
          prpg <= PRPG_SEED;
          misr <= '0;
          cnt  <= '0;
          pat  <= '0;
        end
        S_SHIFT, S_UNLD: begin
          prpg <= prpg_nx;
          misr <= misr_nx;
          if (last_shift) begin
            cnt <= '0;
            st  <= (st == S_SHIFT) ? S_CAPT : S_FIN;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_CAPT: begin
          pat <= pat + 1'b1;
          st  <= (pat == PW'(NPAT - 1)) ? S_UNLD : S_SHIFT;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [CW:0] chk_run;
  always_ff @(posedge clk) begin
    if (!rst_n)       chk_run <= '0;
    else if (scan_en) chk_run <= chk_run + 1'b1;
    else              chk_run <= '0;
  end

  assert_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(scan_en && capture_en));
  assert_capt_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(capture_en) |-> chk_run == (CW+1)'(SHIFT_LEN));
  assert_capt_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    capture_en |=> !capture_en && signature == $past(signature));
  assert_unload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> chk_run == (CW+1)'(SHIFT_LEN));
  assert_done_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done && $stable(signature));
  assert_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done && start |=> scan_en && signature == '0);
endmodule

// File: tb/tb_stumps_bist.sv
module tb_stumps_bist;
  localparam int NC = 4, K = 8, NP = 4;
  logic clk = 0, rst_n = 0, start = 0;
  logic [NC-1:0] scan_out, scan_in;
  logic scan_en, capture_en, done;
  logic [15:0] signature;
  int total = 0, bad = 0, cycles = 0;
  logic [15:0] p, m;
  logic [7:0] ch [NC];
  int len [NC] = '{8, 5, 7, 3};

  stumps_bist dut (.clk(clk), .rst_n(rst_n), .start(start), .scan_out(scan_out),
    .scan_in(scan_in), .scan_en(scan_en), .capture_en(capture_en),
    .signature(signature), .done(done));

  always #4 clk = ~clk;

  always @(posedge clk) begin
    for (int i = 0; i < NC; i++) begin
      if (!rst_n) ch[i] <= 8'h00;
      else if (scan_en) ch[i] <= {ch[i][6:0], scan_in[i]};
      else if (capture_en) ch[i] <= ch[i] ^ {ch[i][0], ch[i][7:1]} ^ (8'h5A + 8'(i));
    end
  end
  always_comb for (int i = 0; i < NC; i++) scan_out[i] = ch[i][len[i]-1];

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d cycles expected<=100000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [NC-1:0] taps(input logic [15:0] x);
    for (int i = 0; i < NC; i++) taps[i] = x[i*4];
  endfunction

  task automatic step(input bit se, input bit ce, input bit dn, input bit pulse);
    logic [NC-1:0] so;
    @(negedge clk);
    chk(scan_en == se && capture_en == ce, "R5/R9 enables", {scan_en, capture_en}, {se, ce});
    chk(done == dn, "R6/R7 done", done, dn);
    chk(signature == m, "R4 signature", signature, m);
    chk(scan_in == taps(p), "R3 scan_in", scan_in, taps(p));
    so = scan_out;
    start = pulse;
    @(posedge clk);
    if (se) begin
      m = {m[14:0], ^(m & 16'hB400)} ^ {12'b0, so};
      p = {p[14:0], ^(p & 16'hB400)};
    end
  endtask

  task automatic session(input int noisy);
    @(negedge clk); start = 1;
    @(posedge clk);
    p = 16'hACE1; m = 16'h0000;
    for (int pt = 0; pt < NP; pt++) begin
      for (int k = 0; k < K; k++) step(1, 0, 0, (noisy != 0) && (k == 3));  // R8 when noisy
      step(0, 1, 0, 1'b0);
    end
    for (int k = 0; k < K; k++) step(1, 0, 0, 1'b0);  // R6 unload
    for (int k = 0; k < 4; k++) step(0, 0, 1, 1'b0);  // R7 hold
  endtask

  initial begin
    p = 16'hACE1; m = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!scan_en && !capture_en && !done && signature == 0, "R1 reset", {done, signature}, 0);
    rst_n = 1;
    for (int k = 0; k < 3; k++) step(0, 0, 0, 1'b0);   // R1 idle without start
    session(0);                                        // R2 start from idle
    session(1);                                        // R2 restart from done, R8 noisy start
    session(0);
    @(negedge clk); start = 1;
    @(posedge clk); p = 16'hACE1; m = 0;
    for (int k = 0; k < 5; k++) step(1, 0, 0, 1'b0);
    @(negedge clk); rst_n = 0;
    @(posedge clk); @(negedge clk);
    chk(!scan_en && !capture_en && !done && signature == 0, "R1 mid-run reset", {done, signature}, 0);
    rst_n = 1; p = 16'hACE1; m = 0;
    for (int k = 0; k < 2; k++) step(0, 0, 0, 1'b0);
    session(1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule